// File: doc/BRIEF.md
# Programmable sampling pulse detector

This block produces the one-clock sampling pulse that paces a sampler, together with a strobe that marks the moment to take the sample. It has two modes. In pass-through mode the input is assumed to already be a pulse one master clock wide at the sample rate, and it is forwarded after resynchronisation. In detect mode the input can be any periodic signal of the right frequency, such as a shift-register clock. The block picks out one chosen edge of that signal, makes a one-clock internal pulse for each such edge, and delays it by a programmable number of clocks.

The input first passes through a two-flop synchronizer. That fixed latency comes before the programmable delay. The mode, edge choice and delay are taken at the moment an edge is found. A pulse that is already travelling through the delay line therefore keeps the settings it started with. The sample strobe is one clock wide. It rises on the first clock edge after the sampling pulse has gone low.

Top module: `samp_pulse_det`

## Requirements
- R1: With det_en = 0, pulse_o in each cycle equals the raw_in level sampled two rising edges earlier (two-flop synchronizer), once any internal pulses still in flight have left.
- R2: With det_en = 1 and rising_sel = 1, each low-to-high change of raw_in produces a pulse_o that is high for exactly one clock. The pulse begins 3 + D rising edges after the first edge that samples the new level, where D is the unsigned value of dly_sel.
- R3: With det_en = 1 and rising_sel = 0, the same holds for high-to-low changes of raw_in. Rising changes then produce no pulse.
- R4: dly_sel (3 bits, unsigned D = 0..7) adds exactly D clocks of delay to the internal pulse, on top of the fixed latency of 3.
- R5: strobe_o is high for one clock. It is registered on the first rising edge after pulse_o has gone low, so it is high in the cycle after the first low cycle that follows a high cycle of pulse_o.
- R6: strobe_o never stays high for two consecutive cycles, and it fires at most once per sampling pulse.
- R7: det_en, rising_sel and dly_sel are sampled in the cycle an edge is detected. Changing them later does not alter or cancel an internal pulse already in flight, and such pulses still appear after det_en is cleared.
- R8: Synchronous reset (rst high at a rising edge) clears the synchronizer, the edge history (to low) and the delay line. pulse_o and strobe_o are low in the cycle after reset. An input held high across reset counts as a rising change after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Raw periodic input (pulse or clock) |
| det_en | input | 1 | 1 = edge-detect mode, 0 = pass-through |
| rising_sel | input | 1 | 1 = detect rising edges, 0 = falling |
| dly_sel | input | 3 | Extra delay of the internal pulse in clocks |
| pulse_o | output | 1 | Sampling pulse (pass-through or internal) |
| strobe_o | output | 1 | One-clock sample strobe after the pulse falls |

## Verification
The hardest situation to reach from the ports is several internal pulses in flight at once, each carrying different settings. It arises when dly_sel, rising_sel or det_en change while earlier edges are still moving through the delay line. The stimulus retunes dly_sel every few cycles under a fast square wave and turns detection off in mid-stream. It also applies random input with random control changes. The reference model records the settings of every cycle and rebuilds each expected pulse from the settings in force when its edge was seen. A reset applied with the input held high covers the cleared edge history.

// File: rtl/samp_pulse_det.sv
module samp_pulse_det #(
  parameter int DLY_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_in,
  input  logic             det_en,
  input  logic             rising_sel,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             pulse_o,
  output logic             strobe_o
);
  localparam int TAPS = 1 << DLY_W;

  logic [SYNC_N-1:0] sync_q;
  logic              hist_q;
  logic [TAPS-1:0]   line_q;
  logic [TAPS-1:0]   inject;
  logic              pulse_q;

  wire lvl = sync_q[SYNC_N-1];
  wire hit = det_en & (rising_sel ? (lvl & ~hist_q) : (~lvl & hist_q));

  always_comb begin
    inject = '0;
    inject[~dly_sel] = hit;
  end

  assign pulse_o = line_q[TAPS-1] | (~det_en & lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      hist_q   <= 1'b0;
      line_q   <= '0;
      pulse_q  <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_N-2:0], raw_in};
      hist_q   <= lvl;
      line_q   <= {line_q[TAPS-2:0], 1'b0} | inject;
      pulse_q  <= pulse_o;
      strobe_o <= pulse_q & ~pulse_o;
    end
  end
endmodule

module samp_pulse_det_chk #(
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             raw_in,
  input logic             det_en,
  input logic             rising_sel,
  input logic [DLY_W-1:0] dly_sel,
  input logic             pulse_o,
  input logic             strobe_o
);
  logic [1:0]       since;
  logic [3:0]       calm_q;
  logic [3:0]       calm;
  logic [DLY_W+1:0] ctl_q;
  logic             rst_q = 1'b0;

  wire [DLY_W+1:0] ctl = {det_en, rising_sel, dly_sel};
  assign calm = (ctl == ctl_q) ? calm_q : 4'd0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    ctl_q <= ctl;
    calm_q <= (calm == 4'd15) ? calm : calm + 4'd1;
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  a_r1_bypass_follow: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && calm >= 4'd9 && !det_en) |-> (pulse_o == $past(raw_in, 2)));

  a_r2_r3_one_wide: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && calm >= 4'd9 && det_en && pulse_o) |=> !pulse_o);

  a_r5_strobe_after_fall: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && strobe_o) |-> (!$past(pulse_o) && $past(pulse_o, 2)));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst_q |-> (!pulse_o && !strobe_o));
endmodule

bind samp_pulse_det samp_pulse_det_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .raw_in(raw_in), .det_en(det_en),
  .rising_sel(rising_sel), .dly_sel(dly_sel),
  .pulse_o(pulse_o), .strobe_o(strobe_o)
);

// File: tb/tb_samp_pulse_det.sv
module tb_samp_pulse_det;
  localparam int N = 8192;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, raw_in = 1'b0, det_en = 1'b0, rising_sel = 1'b1;
  logic [2:0] dly_sel = 3'd0;
  logic pulse_o, strobe_o;

  samp_pulse_det dut (
    .clk(clk), .rst(rst), .raw_in(raw_in), .det_en(det_en),
    .rising_sel(rising_sel), .dly_sel(dly_sel),
    .pulse_o(pulse_o), .strobe_o(strobe_o)
  );

  bit rawh[N], enh[N], polh[N], pm[N];
  int dlyh[N];
  int cyc = 0, last_r = 0, n_cmp = 0, n_bad = 0;
  bit seen = 0, done = 0;
  string tag = "R8";

  function automatic bit rv(int i);
    return (i < 0 || i < last_r) ? 1'b0 : rawh[i];
  endfunction

  function automatic bit pe(int i);
    return (i < 0 || i < last_r) ? 1'b0 : pm[i];
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    bit p, s, e;
    if (cyc < N) begin
      rawh[cyc] = raw_in; enh[cyc] = det_en; polh[cyc] = rising_sel; dlyh[cyc] = int'(dly_sel);
      p = !enh[cyc] && rv(cyc - 2);
      for (int j = cyc - 8; j < cyc; j++) begin
        if (j >= 0 && j >= last_r && enh[j] && (j + 1 + dlyh[j] == cyc)) begin
          e = polh[j] ? (rv(j - 2) && !rv(j - 3)) : (!rv(j - 2) && rv(j - 3));
          if (e) p = 1'b1;
        end
      end
      pm[cyc] = p;
      s = pe(cyc - 2) && !pe(cyc - 1);
      if (seen && cyc >= last_r) begin
        n_cmp++;
        if (pulse_o !== p) begin
          n_bad++;
          $display("FAIL %s pulse_o cycle %0d: actual %b expected %b", tag, cyc, pulse_o, p);
        end
        n_cmp++;
        if (strobe_o !== s) begin
          n_bad++;
          $display("FAIL R5 R6 (%s) strobe_o cycle %0d: actual %b expected %b", tag, cyc, strobe_o, s);
        end
      end
      if (rst) begin
        last_r = cyc + 1;
        seen = 1'b1;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic square(int half, int len);
    for (int k = 0; k < len; k++) begin
      raw_in = ((k / half) % 2) == 1;
      step(1);
    end
    raw_in = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(4);
    // R1: pass-through of one-clock pulses
    tag = "R1";
    for (int k = 0; k < 60; k++) begin
      raw_in = (k % 5 == 0) || (k % 7 == 3);
      step(1);
    end
    raw_in = 1'b0;
    step(12);
    // R2 R4: rising edges at every delay
    det_en = 1'b1; rising_sel = 1'b1;
    for (int d = 0; d < 8; d++) begin
      tag = "R2 R4";
      dly_sel = 3'(d);
      square(3, 24);
      step(12);
    end
    // R3 R4: falling edges at every delay
    rising_sel = 1'b0;
    for (int d = 7; d >= 0; d--) begin
      tag = "R3 R4";
      dly_sel = 3'(d);
      square(2, 20);
      step(12);
    end
    // R7: retune while pulses are in flight, then leave detect mode mid-stream
    tag = "R7";
    rising_sel = 1'b1;
    for (int k = 0; k < 80; k++) begin
      raw_in = ((k / 2) % 2) == 1;
      if (k % 3 == 0) dly_sel = 3'($urandom % 8);
      if (k % 11 == 5) rising_sel = ~rising_sel;
      if (k == 70) det_en = 1'b0;
      step(1);
    end
    raw_in = 1'b0;
    step(12);
    // R8: reset with input held high and pulses in flight
    tag = "R8";
    det_en = 1'b1; rising_sel = 1'b1; dly_sel = 3'd6;
    square(2, 10);
    raw_in = 1'b1;
    step(2);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(14);
    raw_in = 1'b0;
    step(12);
    // R2 R3 R4 R7: random input and settings
    tag = "R2 R3 R4 R7";
    for (int k = 0; k < 600; k++) begin
      raw_in = 1'($urandom % 2);
      if (k % 17 == 0) begin
        det_en = 1'($urandom % 4 != 0);
        rising_sel = 1'($urandom % 2);
        dly_sel = 3'($urandom % 8);
      end
      step(1);
    end
    raw_in = 1'b0;
    step(12);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 6000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule